// File: doc/BRIEF.md
# Branchless Scalar Core

A very small in-order processor core that fetches one 16-bit instruction per step from an internal program store. It executes that instruction against four 8-bit registers, with no branches and no pipelining. It has an arithmetic unit for add, subtract and multiply. It also has a 256-byte data store, an 8-bit input port and a registered 8-bit output port. A write-source multiplexer feeds the register write port from one of four places: the arithmetic unit, the data store, the immediate field or the input port.

A two-bit mode input lets the surrounding control run the core, freeze it, or clear it. The opcode of the instruction at the program counter is driven out for that control to see. The halt instruction makes the core stop with a sticky flag. The program store is filled through a simple write port, normally while the core is held in reset.

Top module: `scalar_core`

## Requirements
- R1: An instruction word is split as opcode in bits 15:12, destination/source register A in bits 11:10, register B in bits 9:8 and an 8-bit immediate in bits 7:0. `opcode_out` always shows bits 15:12 of the word at the program counter.
- R2: Opcode 1 sets A = A + B, opcode 2 sets A = A - B and opcode 3 sets A = A * B. All three keep only the low 8 bits, with no flags.
- R3: Opcode 6 loads the immediate into A, and opcode 7 copies `port_in` into A. Opcode 8 copies A into the output register, which drives `port_out` and keeps its value until the next opcode 8.
- R4: Opcode 4 loads A from data-store address B and opcode 5 stores A at data-store address B, with 8-bit addresses and 8-bit data. A load takes two clock edges: an address edge, then a register-write edge, during which `opcode_out` still shows 4. Every other instruction takes one edge.
- R5: Register reads are combinational and the register write lands on the clock edge, so an instruction sees the result of the instruction just before it.
- R6: `mode` = 2'b00 runs the core. `mode` = 2'b01 stalls it: the program counter, registers, output register, halt flag and load phase all hold.
- R7: `mode` with bit 1 set (2'b10 or 2'b11), or `rst_n` low, clears the program counter, registers, output register, halt flag and load phase. Data-store contents are kept.
- R8: Opcode 9 raises `halted` on its edge. While halted the program counter stays frozen and no further instruction runs, until a reset.
- R9: Opcodes 0 and 10 to 15 change nothing but the program counter, which advances by one.
- R10: The 8-bit program counter advances by one per completed instruction and wraps from 255 to 0.
- R11: When `rom_we` is high, `rom_wdata` is written into program-store word `rom_addr` on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 run, 01 stall, 1x synchronous clear |
| port_in | input | 8 | Input port value sampled by opcode 7 |
| rom_we | input | 1 | Program-store write enable |
| rom_addr | input | 8 | Program-store write address |
| rom_wdata | input | 16 | Program-store write data |
| port_out | output | 8 | Registered output port |
| opcode_out | output | 4 | Opcode of the word at the program counter |
| halted | output | 1 | Sticky halt flag |

## Verification
The assertions assume that the program store is never rewritten while the core is out of reset. The properties on frozen or stable opcodes hold only for that reason, and the write port is included in their conditions so that they cannot fire on it. They also assume that `mode` and `port_in` are known values that change only away from the rising edge. The stimulus loads every program while `rst_n` is low and drives all inputs on the falling edge. Random programs are run only after a preamble has filled all 256 data-store bytes, so that no load returns an unwritten value.

// File: rtl/scalar_pkg.sv
package scalar_pkg;

    localparam int DATA_W  = 8;
    localparam int INST_W  = 16;
    localparam int OPC_W   = 4;
    localparam int RSEL_W  = 2;
    localparam int PC_W    = 8;
    localparam int MADDR_W = 8;

    localparam logic [OPC_W-1:0] OP_ADD  = 4'd1;
    localparam logic [OPC_W-1:0] OP_SUB  = 4'd2;
    localparam logic [OPC_W-1:0] OP_MUL  = 4'd3;
    localparam logic [OPC_W-1:0] OP_LOAD = 4'd4;
    localparam logic [OPC_W-1:0] OP_STOR = 4'd5;
    localparam logic [OPC_W-1:0] OP_IMM  = 4'd6;
    localparam logic [OPC_W-1:0] OP_IN   = 4'd7;
    localparam logic [OPC_W-1:0] OP_OUT  = 4'd8;
    localparam logic [OPC_W-1:0] OP_STOP = 4'd9;

    localparam logic [1:0] MODE_RUN   = 2'b00;
    localparam logic [1:0] MODE_STALL = 2'b01;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_MUL = 2'd2
    } alu_op_e;

    typedef enum logic [1:0] {
        WSRC_ALU  = 2'd0,
        WSRC_MEM  = 2'd1,
        WSRC_IMM  = 2'd2,
        WSRC_PORT = 2'd3
    } wsrc_e;

    typedef struct packed {
        logic              rf_we;
        wsrc_e             wsrc;
        alu_op_e           alu_op;
        logic              mem_req;
        logic              mem_we;
        logic              is_load;
        logic              is_out;
        logic              is_halt;
        logic [RSEL_W-1:0] ra;
        logic [RSEL_W-1:0] rb;
        logic [DATA_W-1:0] imm;
    } dec_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import scalar_pkg::*;
(
    input  logic [INST_W-1:0] inst,
    output logic [OPC_W-1:0]  opcode,
    output dec_t              dec
);

    localparam int RA_HI = INST_W - OPC_W - 1;
    localparam int RB_HI = RA_HI - RSEL_W;

    always_comb begin
        opcode      = inst[INST_W-1 -: OPC_W];
        dec         = '0;
        dec.wsrc    = WSRC_ALU;
        dec.alu_op  = ALU_ADD;
        dec.ra      = inst[RA_HI -: RSEL_W];
        dec.rb      = inst[RB_HI -: RSEL_W];
        dec.imm     = inst[DATA_W-1:0];
        unique case (opcode)
            OP_ADD: begin dec.rf_we = 1'b1; dec.alu_op = ALU_ADD; end
            OP_SUB: begin dec.rf_we = 1'b1; dec.alu_op = ALU_SUB; end
            OP_MUL: begin dec.rf_we = 1'b1; dec.alu_op = ALU_MUL; end
            OP_LOAD: begin
                dec.rf_we   = 1'b1;
                dec.wsrc    = WSRC_MEM;
                dec.mem_req = 1'b1;
                dec.is_load = 1'b1;
            end
            OP_STOR: begin dec.mem_req = 1'b1; dec.mem_we = 1'b1; end
            OP_IMM:  begin dec.rf_we = 1'b1; dec.wsrc = WSRC_IMM; end
            OP_IN:   begin dec.rf_we = 1'b1; dec.wsrc = WSRC_PORT; end
            OP_OUT:  dec.is_out  = 1'b1;
            OP_STOP: dec.is_halt = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import scalar_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_MUL: y = a * b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int W   = 8,
    parameter int SEL = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           we,
    input  logic [SEL-1:0] waddr,
    input  logic [W-1:0]   wdata,
    input  logic [SEL-1:0] ra,
    input  logic [SEL-1:0] rb,
    output logic [W-1:0]   qa,
    output logic [W-1:0]   qb
);

    localparam int NREG = 1 << SEL;

    logic [NREG-1:0][W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (clr) begin
            regs_d = '0;
        end else if (we) begin
            regs_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign qa = regs_q[ra];
    assign qb = regs_q[rb];

endmodule

// File: rtl/sc_dmem.sv
module sc_dmem #(
    parameter int AW = 8,
    parameter int W  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);

    localparam int DEPTH = 1 << AW;

    logic [W-1:0] cells [DEPTH];
    logic [W-1:0] rdata_d, rdata_q;

    always_ff @(posedge clk) begin
        if (req && we) cells[addr] <= wdata;
    end

    always_comb begin
        rdata_d = rdata_q;
        if (req && !we) rdata_d = cells[addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/scalar_core.sv
module scalar_core
    import scalar_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic [DATA_W-1:0] port_in,
    input  logic              rom_we,
    input  logic [PC_W-1:0]   rom_addr,
    input  logic [INST_W-1:0] rom_wdata,
    output logic [DATA_W-1:0] port_out,
    output logic [OPC_W-1:0]  opcode_out,
    output logic              halted
);

    localparam int ROM_DEPTH = 1 << PC_W;

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic              ld_wait;
        logic              halted;
        logic [DATA_W-1:0] out;
    } core_t;

    core_t s_d, s_q;

    logic [INST_W-1:0] rom_q [ROM_DEPTH];
    logic [INST_W-1:0] inst;
    dec_t              dec;
    logic [OPC_W-1:0]  opcode;

    logic              rf_we, rf_clr;
    logic [DATA_W-1:0] rf_wdata, qa, qb, alu_y, mem_q;
    logic              mem_req, mem_we;
    logic              step_ok;
    logic              ld_wait_w;

    always_ff @(posedge clk) begin
        if (rom_we) rom_q[rom_addr] <= rom_wdata;
    end

    assign inst = rom_q[s_q.pc];

    sc_decode u_dec (
        .inst   (inst),
        .opcode (opcode),
        .dec    (dec)
    );

    sc_regfile #(.W(DATA_W), .SEL(RSEL_W)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rf_clr),
        .we    (rf_we),
        .waddr (dec.ra),
        .wdata (rf_wdata),
        .ra    (dec.ra),
        .rb    (dec.rb),
        .qa    (qa),
        .qb    (qb)
    );

    sc_alu #(.W(DATA_W)) u_alu (
        .op (dec.alu_op),
        .a  (qa),
        .b  (qb),
        .y  (alu_y)
    );

    sc_dmem #(.AW(MADDR_W), .W(DATA_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (mem_req),
        .we    (mem_we),
        .addr  (qb),
        .wdata (qa),
        .rdata (mem_q)
    );

    always_comb begin
        unique case (dec.wsrc)
            WSRC_ALU:  rf_wdata = alu_y;
            WSRC_MEM:  rf_wdata = mem_q;
            WSRC_IMM:  rf_wdata = dec.imm;
            WSRC_PORT: rf_wdata = port_in;
            default:   rf_wdata = alu_y;
        endcase
    end

    assign step_ok = rst_n && (mode == MODE_RUN) && !s_q.halted;

    always_comb begin
        s_d     = s_q;
        rf_we   = 1'b0;
        rf_clr  = 1'b0;
        mem_req = 1'b0;
        mem_we  = 1'b0;
        if (mode[1]) begin
            s_d    = '0;
            rf_clr = 1'b1;
        end else if (step_ok) begin
            if (dec.is_halt) begin
                s_d.halted = 1'b1;
            end else if (dec.is_load) begin
                if (!s_q.ld_wait) begin
                    mem_req     = 1'b1;
                    s_d.ld_wait = 1'b1;
                end else begin
                    rf_we       = 1'b1;
                    s_d.ld_wait = 1'b0;
                    s_d.pc      = s_q.pc + 1'b1;
                end
            end else begin
                rf_we   = dec.rf_we;
                mem_req = dec.mem_req;
                mem_we  = dec.mem_we;
                if (dec.is_out) s_d.out = qa;
                s_d.pc = s_q.pc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign port_out   = s_q.out;
    assign halted     = s_q.halted;
    assign opcode_out = opcode;
    assign ld_wait_w  = s_q.ld_wait;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       rom_we,
    input logic [3:0] opcode_out,
    input logic [7:0] port_out,
    input logic       halted,
    input logic       ld_wait
);

    assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !mode[1]) |=> halted);

    assert_halt_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !mode[1] && !rom_we) |=> $stable(opcode_out));

    assert_stall_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && !rom_we) |=> ($stable(opcode_out) && $stable(port_out)
                                         && $stable(halted) && $stable(ld_wait)));

    assert_clear_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mode[1] |=> (port_out == 8'd0 && !halted && !ld_wait));

    assert_out_only_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode[1] && !(mode == 2'b00 && !halted && opcode_out == 4'd8)) |=> $stable(port_out));

    assert_load_two_edges_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && !halted && opcode_out == 4'd4 && !ld_wait && !rom_we)
            |=> (ld_wait && $stable(opcode_out)));

endmodule

bind scalar_core sc_core_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .rom_we     (rom_we),
    .opcode_out (opcode_out),
    .port_out   (port_out),
    .halted     (halted),
    .ld_wait    (ld_wait_w)
);

// File: tb/sim_scalar_core.sv
module sim_scalar_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b01;
    logic [7:0]  port_in = 8'd0;
    logic        rom_we = 1'b0;
    logic [7:0]  rom_addr = 8'd0;
    logic [15:0] rom_wdata = 16'd0;
    logic [7:0]  port_out;
    logic [3:0]  opcode_out;
    logic        halted;

    always #4 clk = ~clk;

    scalar_core u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .port_in(port_in),
        .rom_we(rom_we), .rom_addr(rom_addr), .rom_wdata(rom_wdata),
        .port_out(port_out), .opcode_out(opcode_out), .halted(halted)
    );

    int checks = 0;
    int errors = 0;

    // reference model, updated from the same inputs as the design
    logic [15:0] m_rom [256];
    logic [15:0] img   [256];
    logic [7:0]  m_mem [256];
    logic [7:0]  m_reg [4];
    logic [7:0]  m_pc, m_out, m_ldbuf;
    logic        m_wait, m_halt;

    function automatic logic [15:0] enc(int op, int a, int b, int imm);
        return {4'(op), 2'(a), 2'(b), 8'(imm)};
    endfunction

    task automatic model_step();
        logic [15:0] w;
        logic [3:0]  op;
        logic [1:0]  a, b;
        w  = m_rom[m_pc];
        op = w[15:12];
        a  = w[11:10];
        b  = w[9:8];
        case (op)
            4'd1: m_reg[a] = m_reg[a] + m_reg[b];
            4'd2: m_reg[a] = m_reg[a] - m_reg[b];
            4'd3: m_reg[a] = m_reg[a] * m_reg[b];
            4'd4: if (!m_wait) begin m_ldbuf = m_mem[m_reg[b]]; m_wait = 1'b1; end
                  else begin m_reg[a] = m_ldbuf; m_wait = 1'b0; end
            4'd5: m_mem[m_reg[b]] = m_reg[a];
            4'd6: m_reg[a] = w[7:0];
            4'd7: m_reg[a] = port_in;
            4'd8: m_out = m_reg[a];
            4'd9: m_halt = 1'b1;
            default: ;
        endcase
        if (op != 4'd9 && !(op == 4'd4 && m_wait)) m_pc = m_pc + 8'd1;
    endtask

    always @(posedge clk) begin
        if (!rst_n || mode[1]) begin
            m_pc = 8'd0; m_out = 8'd0; m_wait = 1'b0; m_halt = 1'b0;
            for (int r = 0; r < 4; r++) m_reg[r] = 8'd0;
        end else if (mode == 2'b00 && !m_halt) begin
            model_step();
        end
        if (rom_we) m_rom[rom_addr] = rom_wdata;
    end

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "port_out", {8'd0, port_out}, {8'd0, m_out});
        chk(tag, "halted", {15'd0, halted}, {15'd0, m_halt});
        chk(tag, "opcode_out", {12'd0, opcode_out}, {12'd0, m_rom[m_pc][15:12]});
    endtask

    task automatic fill(input logic [15:0] w);
        for (int i = 0; i < 256; i++) img[i] = w;
    endtask

    task automatic load_prog();
        @(negedge clk);
        rst_n = 1'b0;
        mode  = 2'b00;
        for (int i = 0; i < 256; i++) begin
            rom_we = 1'b1; rom_addr = 8'(i); rom_wdata = img[i];
            @(negedge clk);
        end
        rom_we = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R7", "reset port_out", {8'd0, port_out}, 16'd0);
        chk("R7", "reset halted", {15'd0, halted}, 16'd0);
        chk("R11", "loaded opcode", {12'd0, opcode_out}, {12'd0, img[0][15:12]});
    endtask

    task automatic run(input int n, input string tag, input bit rnd);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check_all(tag);
            if (rnd) begin
                int r;
                r = int'($urandom % 100);
                mode = (r < 85) ? 2'b00 : (r < 97) ? 2'b01 : {1'b1, 1'($urandom)};
                port_in = 8'($urandom);
            end else begin
                mode = 2'b00;
            end
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual expired expected finished");
        finish_run();
    end

    initial begin
        logic [3:0] held;
        void'($urandom(32'd2718));
        for (int i = 0; i < 256; i++) begin m_rom[i] = 16'd0; m_mem[i] = 8'd0; end

        // fill every data-store byte: R4 store path
        for (int c = 0; c < 4; c++) begin
            fill(enc(9, 0, 0, 0));
            for (int i = 0; i < 64; i++) begin
                img[3*i]   = enc(6, 0, 0, c*64 + i);
                img[3*i+1] = enc(6, 1, 0, (c*64 + i) * 37 + 11);
                img[3*i+2] = enc(5, 1, 0, 0);
            end
            load_prog();
            run(200, "R4", 1'b0);
        end

        // R2 R5 wrapping arithmetic, back-to-back dependence
        fill(enc(9, 0, 0, 0));
        img[0] = enc(6, 0, 0, 20);  img[1] = enc(6, 1, 0, 13);
        img[2] = enc(3, 0, 1, 0);   img[3] = enc(8, 0, 0, 0);
        img[4] = enc(6, 2, 0, 3);   img[5] = enc(6, 3, 0, 5);
        img[6] = enc(2, 2, 3, 0);   img[7] = enc(8, 2, 0, 0);
        img[8] = enc(6, 0, 0, 200); img[9] = enc(6, 1, 0, 100);
        img[10] = enc(1, 0, 1, 0);  img[11] = enc(8, 0, 0, 0);
        load_prog();
        run(4, "R2", 1'b0);
        chk("R2", "20*13 low byte", {8'd0, port_out}, 16'd4);
        run(4, "R2", 1'b0);
        chk("R2", "3-5 wrap", {8'd0, port_out}, 16'd254);
        run(4, "R5", 1'b0);
        chk("R5", "200+100 used next", {8'd0, port_out}, 16'd44);

        // R6 stall in the middle of the same program
        load_prog();
        run(2, "R6", 1'b0);
        held = opcode_out;
        mode = 2'b01;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk("R6", "stalled opcode", {12'd0, opcode_out}, {12'd0, held});
            chk("R6", "stalled port", {8'd0, port_out}, 16'd0);
        end
        run(20, "R6", 1'b0);
        chk("R6", "result after stall", {8'd0, port_out}, 16'd44);

        // R3 input, output register holds
        fill(enc(9, 0, 0, 0));
        port_in = 8'h5A;
        img[0] = enc(7, 1, 0, 0); img[1] = enc(8, 1, 0, 0);
        img[2] = enc(6, 2, 0, 8'h33); img[3] = enc(1, 1, 2, 0);
        load_prog();
        run(10, "R3", 1'b0);
        chk("R3", "port holds last write", {8'd0, port_out}, 16'h5A);

        // R4 load takes two edges
        fill(enc(9, 0, 0, 0));
        img[0] = enc(6, 0, 0, 8'h80); img[1] = enc(6, 1, 0, 8'hC3);
        img[2] = enc(5, 1, 0, 0);     img[3] = enc(6, 1, 0, 0);
        img[4] = enc(4, 2, 0, 0);     img[5] = enc(8, 2, 0, 0);
        load_prog();
        run(5, "R4", 1'b0);
        chk("R4", "load second edge opcode", {12'd0, opcode_out}, 16'd4);
        run(1, "R4", 1'b0);
        chk("R4", "no write yet", {8'd0, port_out}, 16'd0);
        run(1, "R4", 1'b0);
        chk("R4", "loaded value", {8'd0, port_out}, 16'hC3);

        // R9 no-op opcodes, R8 halt afterwards
        fill(enc(9, 0, 0, 0));
        img[0] = enc(0, 3, 3, 8'hFF);
        for (int i = 1; i < 7; i++) img[i] = enc(9 + i, 1, 2, 8'h55);
        img[7] = enc(6, 0, 0, 7); img[8] = enc(8, 0, 0, 0);
        load_prog();
        run(9, "R9", 1'b0);
        chk("R9", "after no-ops", {8'd0, port_out}, 16'd7);
        chk("R9", "pc reached 9", {12'd0, opcode_out}, 16'd9);
        run(1, "R8", 1'b0);
        chk("R8", "halted raised", {15'd0, halted}, 16'd1);

        // R8 freeze, then R7 clear mode
        fill(enc(0, 0, 0, 0));
        img[0] = enc(6, 0, 0, 9); img[1] = enc(8, 0, 0, 0); img[2] = enc(9, 0, 0, 0);
        img[3] = enc(6, 0, 0, 1); img[4] = enc(8, 0, 0, 0);
        load_prog();
        run(40, "R8", 1'b0);
        chk("R8", "frozen port", {8'd0, port_out}, 16'd9);
        chk("R8", "frozen opcode", {12'd0, opcode_out}, 16'd9);
        mode = 2'b10;
        @(negedge clk);
        chk("R7", "clear port", {8'd0, port_out}, 16'd0);
        chk("R7", "clear halted", {15'd0, halted}, 16'd0);
        chk("R7", "clear pc", {12'd0, opcode_out}, 16'd6);
        run(5, "R7", 1'b0);

        // R7 data store survives resets
        fill(enc(9, 0, 0, 0));
        img[0] = enc(6, 0, 0, 8'h80); img[1] = enc(4, 2, 0, 0); img[2] = enc(8, 2, 0, 0);
        load_prog();
        run(6, "R7", 1'b0);
        chk("R7", "memory kept", {8'd0, port_out}, 16'hC3);

        // R10 program counter wrap
        fill(enc(0, 0, 0, 0));
        img[0] = enc(6, 0, 0, 1); img[1] = enc(1, 1, 0, 0); img[2] = enc(8, 1, 0, 0);
        load_prog();
        run(259, "R10", 1'b0);
        chk("R10", "second pass after wrap", {8'd0, port_out}, 16'd2);

        // R1 random programs, random modes
        for (int p = 0; p < 30; p++) begin
            int len;
            fill(enc(9, 0, 0, 0));
            len = 20 + int'($urandom % 200);
            for (int i = 0; i < len; i++) begin
                logic [15:0] w;
                w = 16'($urandom);
                if (w[15:12] == 4'd9) w[15:12] = 4'd6;
                img[i] = w;
            end
            load_prog();
            run(300, "R1", 1'b1);
        end

        finish_run();
    end

endmodule